// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status-Tagged Word Queue

This block receives asynchronous serial frames on a single line and delivers them to a host through a small queue. The line is resampled into the clock domain and watched on every pulse of a baud tick that runs at sixteen times the bit rate. A falling edge on an idle line starts a candidate frame. The candidate is kept only if the line is still low at the middle of the start bit. Each data bit is then sampled once, at the middle of its bit period, with the least significant bit first. A mode input selects eight or nine data bits. One stop bit follows the data bits.

When the stop bit has been sampled, the finished word is pushed into a two-entry queue. Each entry stores the data byte, the ninth bit and a framing-error flag, so this status stays with its own word. The host always sees the oldest entry. It pops that entry with a one-cycle read strobe. A ready flag is high while the queue holds data, and it is gated by an interrupt enable to form the interrupt output. If a word finishes while the queue is full, that word is dropped and a sticky overrun flag is set. While the overrun flag is set, no word enters the queue. The host clears the flag by driving the receive enable low for at least one cycle. Words already in the queue are kept.

Top module: `async_rx_queue`

## Requirements
- R1: After reset the queue is empty, and rx_ready, irq, overrun, head_data, head_bit9 and head_frame_err are all 0.
- R2: A start bit is accepted only if the line is still low at the eighth baud tick after the falling edge is seen. A low pulse that has ended by then produces no word.
- R3: With nine_bit_mode=0, eight data bits are taken least significant bit first and appear on head_data. head_bit9 reads 0 for such a word.
- R4: With nine_bit_mode=1, nine data bits are taken least significant bit first. Bits 0 to 7 appear on head_data and bit 8 appears on head_bit9.
- R5: A word enters the queue only after its stop bit has been sampled. head_frame_err is 1 for a word whose stop bit was sampled as 0 and 0 for a word whose stop bit was sampled as 1.
- R6: The queue holds two words. head_data, head_bit9 and head_frame_err always show the oldest entry, and a read strobe makes the next entry's three values appear.
- R7: rx_ready is 1 exactly while the queue is not empty. irq equals rx_ready AND irq_en.
- R8: A word that completes while the queue holds two entries is discarded and sets overrun. The two stored entries are unchanged.
- R9: While overrun is 1, no completed word is stored, even if the queue has space.
- R10: overrun stays 1 while rx_en is high. It clears in the cycle after rx_en is low. Queue contents survive this, and reception resumes when rx_en returns high.
- R11: While rx_en is 0, no frame is received and any frame in progress is abandoned.
- R12: A read strobe while the queue is empty has no effect: rx_ready stays 0 and a word received afterwards reads back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; a low level clears overrun |
| baud_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| nine_bit_mode | input | 1 | 1 selects nine data bits, 0 selects eight |
| rd_strobe | input | 1 | Pops the oldest queue entry |
| irq_en | input | 1 | Interrupt enable |
| head_data | output | 8 | Data byte of the oldest entry |
| head_bit9 | output | 1 | Ninth bit of the oldest entry |
| head_frame_err | output | 1 | Framing-error flag of the oldest entry |
| rx_ready | output | 1 | Queue not empty |
| irq | output | 1 | rx_ready gated by irq_en |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default parameters: an oversampling ratio of 16, a two-stage line synchronizer and a queue depth of two. With a depth of two, the overrun path is reached after only three unread frames, and a fourth frame then exercises the blocking that overrun imposes. The bench pulses the baud tick once every four clocks, which leaves room for the synchronizer latency between a line change and the next tick. Under this timing, the mid-bit sample points and the rejection of a short start pulse fall on predictable ticks.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   typedef struct packed {
      logic       ferr;
      logic       bit9;
      logic [7:0] data;
   } rx_word_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   initial begin
      assert (STAGES >= 1) else $error("rx_line_sync: STAGES must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b1;
            else        q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '1;
            else        q <= {q[STAGES-2:0], din};
         end
         assign dout = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
   import async_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     tick,
   input  logic     line,
   input  logic     nine,
   output logic     done,
   output rx_word_t word
);

   localparam int CNT_W = $clog2(OVS);
   localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

   initial begin
      assert (OVS >= 4 && (OVS % 2) == 0) else $error("rx_frame_engine: OVS must be even and at least 4");
   end

   rx_state_e        st;
   logic [CNT_W-1:0] cnt;
   logic [3:0]       bitn;
   logic [8:0]       sr;
   logic             nine_q;
   logic [3:0]       last_bit;

   assign last_bit = nine_q ? 4'd8 : 4'd7;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RX_IDLE;
         cnt    <= '0;
         bitn   <= '0;
         sr     <= '0;
         nine_q <= 1'b0;
         done   <= 1'b0;
         word   <= '0;
      end else begin
         done <= 1'b0;
         if (!en) begin
            st  <= RX_IDLE;
            cnt <= '0;
         end else if (tick) begin
            unique case (st)
               RX_IDLE: begin
                  cnt <= '0;
                  if (!line) begin
                     st     <= RX_START;
                     nine_q <= nine;
                  end
               end
               RX_START: begin
                  if (cnt == MID_CNT) begin
                     cnt  <= '0;
                     bitn <= '0;
                     st   <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == LAST_CNT) begin
                     cnt <= '0;
                     sr  <= {line, sr[8:1]};
                     if (bitn == last_bit) st <= RX_STOP;
                     else                  bitn <= bitn + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == LAST_CNT) begin
                     cnt       <= '0;
                     st        <= RX_IDLE;
                     done      <= 1'b1;
                     word.ferr <= ~line;
                     word.bit9 <= nine_q & sr[8];
                     word.data <= nine_q ? sr[7:0] : sr[8:1];
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   // R11: a disabled receiver sits in idle
   a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> st == RX_IDLE);

   // R5: a completed word is announced for one cycle only
   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: leaving the start state toward data only on a tick
   a_r2_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_START && !tick) |=> st != RX_DATA);

endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
   import async_rx_pkg::*;
#(
   parameter int DEPTH = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     wr,
   input  rx_word_t wdata,
   input  logic     rd,
   output rx_word_t head,
   output logic     not_empty,
   output logic     ovr
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

   initial begin
      assert (DEPTH >= 2) else $error("rx_word_fifo: DEPTH must be at least 2");
   end

   rx_word_t         mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic [CNT_W-1:0] cnt;
   logic             empty, full, rd_ok, wr_ok, drop;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == LAST_PTR) ? '0 : p + 1'b1;
   endfunction

   assign empty = (cnt == '0);
   assign full  = (cnt == FULL_CNT);
   assign rd_ok = rd && !empty;
   assign wr_ok = wr && !ovr && (!full || rd_ok);
   assign drop  = wr && !ovr && full && !rd_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         ovr <= 1'b0;
      end else begin
         if (wr_ok) wp <= step(wp);
         if (rd_ok) rp <= step(rp);
         if (wr_ok && !rd_ok)      cnt <= cnt + 1'b1;
         else if (rd_ok && !wr_ok) cnt <= cnt - 1'b1;
         if (!en)       ovr <= 1'b0;
         else if (drop) ovr <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= wdata;
   end

   assign head      = empty ? '0 : mem[rp];
   assign not_empty = !empty;

   // R6: occupancy never passes the depth
   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL_CNT);

   // R8: overrun holds while enabled
   a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && en) |=> ovr);

   // R9: no growth of the queue while overrun is flagged
   a_r9_no_push_in_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && en) |=> cnt <= $past(cnt));

   // R10: disabling clears overrun
   a_r10_clear_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !ovr);

   // R12: a read of an empty queue leaves it empty
   a_r12_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && empty && !wr) |=> cnt == '0);

endmodule

// File: rtl/async_rx_queue.sv
module async_rx_queue
   import async_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int FIFO_DEPTH  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_en,
   input  logic       baud_tick,
   input  logic       rx_in,
   input  logic       nine_bit_mode,
   input  logic       rd_strobe,
   input  logic       irq_en,
   output logic [7:0] head_data,
   output logic       head_bit9,
   output logic       head_frame_err,
   output logic       rx_ready,
   output logic       irq,
   output logic       overrun
);

   logic     line_s;
   logic     word_done;
   rx_word_t word;
   rx_word_t head;

   rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_in),
      .dout (line_s)
   );

   rx_frame_engine #(.OVS(OVS)) u_engine (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (rx_en),
      .tick (baud_tick),
      .line (line_s),
      .nine (nine_bit_mode),
      .done (word_done),
      .word (word)
   );

   rx_word_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (rx_en),
      .wr       (word_done),
      .wdata    (word),
      .rd       (rd_strobe),
      .head     (head),
      .not_empty(rx_ready),
      .ovr      (overrun)
   );

   assign head_data      = head.data;
   assign head_bit9      = head.bit9;
   assign head_frame_err = head.ferr;
   assign irq            = rx_ready & irq_en;

   // R7: ready cannot rise without a completed word
   a_r7_ready_from_word: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_ready && !word_done) |=> !rx_ready);

endmodule

// File: tb/sim_async_rx_queue.sv
module sim_async_rx_queue;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0;
   logic       baud_tick = 1'b0;
   logic       rx_in = 1'b1;
   logic       nine_bit_mode = 1'b0;
   logic       rd_strobe = 1'b0;
   logic       irq_en = 1'b0;
   logic [7:0] head_data;
   logic       head_bit9, head_frame_err, rx_ready, irq, overrun;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   async_rx_queue u0 (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .baud_tick(baud_tick),
      .rx_in(rx_in), .nine_bit_mode(nine_bit_mode), .rd_strobe(rd_strobe),
      .irq_en(irq_en), .head_data(head_data), .head_bit9(head_bit9),
      .head_frame_err(head_frame_err), .rx_ready(rx_ready), .irq(irq),
      .overrun(overrun)
   );

   // baud tick: one clock high out of every four
   initial begin
      forever begin
         repeat (3) @(posedge clk);
         baud_tick <= 1'b1;
         @(posedge clk);
         baud_tick <= 1'b0;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         do @(negedge clk); while (!baud_tick);
      end
   endtask

   task automatic send_frame(input logic nine, input logic [8:0] d, input logic stopv);
      wait_ticks(1);
      nine_bit_mode = nine;
      rx_in = 1'b0;
      wait_ticks(16);
      for (int i = 0; i < (nine ? 9 : 8); i++) begin
         rx_in = d[i];
         wait_ticks(16);
      end
      rx_in = stopv;
      wait_ticks(16);
      rx_in = 1'b1;
      wait_ticks(4);
   endtask

   task automatic pop();
      @(negedge clk) rd_strobe = 1'b1;
      @(negedge clk) rd_strobe = 1'b0;
   endtask

   task automatic chk_head(input string req, input logic [7:0] d, input logic b9, input logic fe);
      chk(req, "head_data", {24'd0, head_data}, {24'd0, d});
      chk(req, "head_bit9", {31'd0, head_bit9}, {31'd0, b9});
      chk(req, "head_frame_err", {31'd0, head_frame_err}, {31'd0, fe});
   endtask

   // vector: {nine, stop, irq_en, data[8:0]}
   localparam int NV = 6;
   localparam logic [11:0] VEC [NV] = '{
      {1'b0, 1'b1, 1'b1, 9'h0A5},
      {1'b1, 1'b1, 1'b0, 9'h15A},
      {1'b0, 1'b1, 1'b1, 9'h1FF},
      {1'b0, 1'b0, 1'b0, 9'h000},
      {1'b1, 1'b0, 1'b1, 9'h101},
      {1'b0, 1'b1, 1'b1, 9'h080}
   };

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1", "rx_ready", {31'd0, rx_ready}, 0);
      chk("R1", "irq", {31'd0, irq}, 0);
      chk("R1", "overrun", {31'd0, overrun}, 0);
      chk_head("R1", 8'h00, 1'b0, 1'b0);
      rst_n = 1'b1;
      rx_en = 1'b1;
      wait_ticks(4);

      // R12 read of empty queue
      pop();
      chk("R12", "rx_ready after empty read", {31'd0, rx_ready}, 0);

      // table walk: R3 R4 R5 R7
      for (int v = 0; v < NV; v++) begin
         logic nine, stopv, ie;
         logic [8:0] d;
         {nine, stopv, ie, d} = VEC[v];
         irq_en = ie;
         send_frame(nine, d, stopv);
         chk("R7", "rx_ready with word", {31'd0, rx_ready}, 1);
         chk("R7", "irq", {31'd0, irq}, {31'd0, ie});
         chk_head(nine ? "R4" : "R3", d[7:0], nine & d[8], ~stopv);
         pop();
         chk("R7", "rx_ready after read", {31'd0, rx_ready}, 0);
         chk("R7", "irq after read", {31'd0, irq}, 0);
      end
      irq_en = 1'b1;

      // R2 short start pulse rejected
      wait_ticks(1);
      rx_in = 1'b0;
      wait_ticks(4);
      rx_in = 1'b1;
      wait_ticks(40);
      chk("R2", "rx_ready after glitch", {31'd0, rx_ready}, 0);

      // R6 per-entry status through two entries
      send_frame(1'b1, 9'h0C3, 1'b0);
      send_frame(1'b1, 9'h13C, 1'b1);
      chk_head("R6", 8'hC3, 1'b0, 1'b1);
      pop();
      chk("R6", "rx_ready with one left", {31'd0, rx_ready}, 1);
      chk_head("R6", 8'h3C, 1'b1, 1'b0);
      pop();
      chk("R6", "rx_ready drained", {31'd0, rx_ready}, 0);

      // R8 overrun on third word
      send_frame(1'b0, 9'h011, 1'b1);
      send_frame(1'b0, 9'h022, 1'b1);
      chk("R8", "overrun before third", {31'd0, overrun}, 0);
      send_frame(1'b0, 9'h033, 1'b1);
      chk("R8", "overrun after third", {31'd0, overrun}, 1);
      // R9 fourth word blocked
      send_frame(1'b0, 9'h044, 1'b1);
      chk_head("R8", 8'h11, 1'b0, 1'b0);
      pop();
      chk_head("R8", 8'h22, 1'b0, 1'b0);
      pop();
      chk("R9", "rx_ready after two reads", {31'd0, rx_ready}, 0);
      send_frame(1'b0, 9'h055, 1'b1);
      chk("R9", "no store while overrun", {31'd0, rx_ready}, 0);
      chk("R10", "overrun held while enabled", {31'd0, overrun}, 1);

      // R10 clear by enable cycle, contents kept
      send_frame(1'b0, 9'h066, 1'b1);
      chk("R9", "still blocked", {31'd0, rx_ready}, 0);
      @(negedge clk) rx_en = 1'b0;
      @(negedge clk);
      chk("R10", "overrun cleared", {31'd0, overrun}, 0);
      // R11 disabled receiver takes nothing
      send_frame(1'b0, 9'h077, 1'b1);
      chk("R11", "no word while disabled", {31'd0, rx_ready}, 0);
      @(negedge clk) rx_en = 1'b1;
      send_frame(1'b0, 9'h088, 1'b1);
      chk("R10", "reception resumed", {31'd0, rx_ready}, 1);
      send_frame(1'b0, 9'h099, 1'b1);
      @(negedge clk) rx_en = 1'b0;
      @(negedge clk) rx_en = 1'b1;
      chk("R10", "queue kept across enable cycle", {31'd0, rx_ready}, 1);
      chk_head("R10", 8'h88, 1'b0, 1'b0);
      pop();
      chk_head("R10", 8'h99, 1'b0, 1'b0);
      pop();

      // R12 empty read then normal word
      pop();
      send_frame(1'b0, 9'h05A, 1'b1);
      chk_head("R12", 8'h5A, 1'b0, 1'b0);
      pop();

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule